// File: doc/BRIEF.md
# Banked Memory Chip-Select Decoder

This block is the address-decoding stage of a small microcontroller memory system. It takes the upper address bits, the three bus strobes and a set of gating enables. From these it drives active-low chip selects for eight equally sized memory blocks. It also drives the select and output enable of one device that holds both program code and data.

For a large data device, the block keeps a small bank register that the host writes. The bank value is placed above the 16 bus address bits, so the large device can reach beyond 64K bytes. The block generates no bus timing. The block-select and shared-device outputs are purely combinational, and only the bank register is clocked.

Top module: `banked_cs_decoder`

## Requirements
- R1: When the gate is open, exactly one of `blk_cs_n[7:0]` is low, namely bit k where k = `addr[15:13]`; at no time is more than one low.
- R2: The gate is open only when `gate_en[0]` is high and both `gate_en[1]` and `gate_en[2]` are low (default `EN_POL` = 3'b001, one bit per enable, 1 = active high); any other `gate_en` value drives all of `blk_cs_n` high.
- R3: `big_addr[15:0]` always equals `addr[15:0]`.
- R4: `shared_cs_n` is low exactly when a code fetch (`code_rd_n` low) targets 0x0000–0x7FFF (`addr[15]`=0) or a data read (`data_rd_n` low) targets 0x8000–0xFFFF (`addr[15]`=1).
- R5: `shared_oe_n` is the AND of `code_rd_n` and `data_rd_n`, so it goes low if either strobe is low, whatever the address.
- R6: `big_oe_n` follows `data_rd_n`, `big_we_n` follows `data_wr_n`, and `big_cs_n` is low exactly when either data strobe is low; `code_rd_n` has no effect on these three outputs.
- R7: When `bank_we` is high at a rising clock edge, `bank_wdata` appears on `big_addr[17:16]` after that edge; otherwise the bank bits hold.
- R8: Asserting `rst_n` low clears the bank bits to 0 at once, without a clock edge; the release of reset is synchronized, and the bank register accepts writes from the third rising edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bank register |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Bus address |
| code_rd_n | input | 1 | Code-fetch strobe, active low |
| data_rd_n | input | 1 | Data-read strobe, active low |
| data_wr_n | input | 1 | Data-write strobe, active low |
| gate_en | input | 3 | Decoder gating enables, polarity set by EN_POL |
| bank_we | input | 1 | Bank register write enable |
| bank_wdata | input | 2 | New bank value |
| blk_cs_n | output | 8 | Block chip selects, active low |
| shared_cs_n | output | 1 | Shared code/data device select, active low |
| shared_oe_n | output | 1 | Shared device output enable, active low |
| big_cs_n | output | 1 | Large data device select, active low |
| big_oe_n | output | 1 | Large device output enable, active low |
| big_we_n | output | 1 | Large device write enable, active low |
| big_addr | output | 18 | Bank bits above the bus address |

## Verification
Assertions check on every cycle the parts of the behaviour that hold at all times. At most one block select is active, and the addressed select is the active one whenever the gate is open. A closed gate silences all block selects. The low address bits pass through, the shared select only fires inside the correct half-range, and the large device's strobes track the data strobes. The bank bits either hold or take the value written in the cycle before.

Some behaviours only the bench scenarios can show. These are the specific select patterns for chosen addresses, cross-half accesses that must leave the shared select inactive, and each single enable at its inactive level. The bench also checks the bank value across writes and holds, and shows that reset clears the bank bits at once without a clock edge.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
  localparam int unsigned CSD_ADDR_W = 16;
  localparam int unsigned CSD_SEL_W  = 3;
  localparam int unsigned CSD_BANK_W = 2;
  localparam int unsigned CSD_NEN    = 3;

  typedef struct packed {
    logic code_rd_n;
    logic data_rd_n;
    logic data_wr_n;
  } strobes_t;
endpackage

// File: rtl/csdec_rst_sync.sv
module csdec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_q_n = stage_q[1];
endmodule

// File: rtl/csdec_sel_decoder.sv
module csdec_sel_decoder #(
  parameter int unsigned SEL_W = 3,
  parameter int unsigned NEN   = 3,
  parameter logic [NEN-1:0] EN_POL = 3'b001,
  localparam int unsigned NOUT = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [NEN-1:0]   en,
  output logic [NOUT-1:0]  y_n
);
  logic gate_open;

  always_comb gate_open = &(en ~^ EN_POL);

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    assign y_n[i] = ~(gate_open && (sel == SEL_W'(i)));
  end
endmodule

// File: rtl/csdec_shared_ctl.sv
import csdec_pkg::*;

module csdec_shared_ctl (
  input  logic     upper_half,
  input  strobes_t stb,
  output logic     cs_n,
  output logic     oe_n
);
  logic code_hit;
  logic data_hit;

  always_comb begin
    code_hit = !stb.code_rd_n && !upper_half;
    data_hit = !stb.data_rd_n &&  upper_half;
    cs_n     = !(code_hit || data_hit);
    oe_n     = stb.code_rd_n & stb.data_rd_n;
  end
endmodule

// File: rtl/csdec_bank_reg.sv
module csdec_bank_reg #(
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] bank_q
);
  logic [BANK_W-1:0] bank_d;

  always_comb bank_d = we ? wdata : bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_d;
  end
endmodule

// File: rtl/banked_cs_decoder.sv
import csdec_pkg::*;

module banked_cs_decoder #(
  parameter int unsigned ADDR_W = CSD_ADDR_W,
  parameter int unsigned SEL_W  = CSD_SEL_W,
  parameter int unsigned BANK_W = CSD_BANK_W,
  parameter logic [CSD_NEN-1:0] EN_POL = 3'b001,
  localparam int unsigned NBLK  = 1 << SEL_W,
  localparam int unsigned BIG_W = ADDR_W + BANK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               code_rd_n,
  input  logic               data_rd_n,
  input  logic               data_wr_n,
  input  logic [CSD_NEN-1:0] gate_en,
  input  logic               bank_we,
  input  logic [BANK_W-1:0]  bank_wdata,
  output logic [NBLK-1:0]    blk_cs_n,
  output logic               shared_cs_n,
  output logic               shared_oe_n,
  output logic               big_cs_n,
  output logic               big_oe_n,
  output logic               big_we_n,
  output logic [BIG_W-1:0]   big_addr
);
  strobes_t          stb;
  logic              rst_q_n;
  logic [BANK_W-1:0] bank_q;

  always_comb begin
    stb.code_rd_n = code_rd_n;
    stb.data_rd_n = data_rd_n;
    stb.data_wr_n = data_wr_n;
  end

  csdec_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  csdec_sel_decoder #(
    .SEL_W  (SEL_W),
    .NEN    (CSD_NEN),
    .EN_POL (EN_POL)
  ) u_dec (
    .sel (addr[ADDR_W-1 -: SEL_W]),
    .en  (gate_en),
    .y_n (blk_cs_n)
  );

  csdec_shared_ctl u_shared (
    .upper_half (addr[ADDR_W-1]),
    .stb        (stb),
    .cs_n       (shared_cs_n),
    .oe_n       (shared_oe_n)
  );

  csdec_bank_reg #(
    .BANK_W (BANK_W)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .we     (bank_we),
    .wdata  (bank_wdata),
    .bank_q (bank_q)
  );

  always_comb begin
    big_oe_n = stb.data_rd_n;
    big_we_n = stb.data_wr_n;
    big_cs_n = stb.data_rd_n & stb.data_wr_n;
    big_addr = {bank_q, addr};
  end
endmodule

// File: rtl/csdec_chk.sv
module csdec_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned BANK_W = 2,
  parameter logic [2:0]  EN_POL = 3'b001,
  localparam int unsigned NBLK  = 1 << SEL_W,
  localparam int unsigned BIG_W = ADDR_W + BANK_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_q_n,
  input logic [ADDR_W-1:0] addr,
  input logic              code_rd_n,
  input logic              data_rd_n,
  input logic              data_wr_n,
  input logic [2:0]        gate_en,
  input logic              bank_we,
  input logic [BANK_W-1:0] bank_wdata,
  input logic [NBLK-1:0]   blk_cs_n,
  input logic              shared_cs_n,
  input logic              shared_oe_n,
  input logic              big_cs_n,
  input logic              big_oe_n,
  input logic              big_we_n,
  input logic [BIG_W-1:0]  big_addr
);
  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~blk_cs_n));

  p_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en == EN_POL) |-> !blk_cs_n[addr[ADDR_W-1 -: SEL_W]]);

  p_gate_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en != EN_POL) |-> (&blk_cs_n));

  p_low_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    big_addr[ADDR_W-1:0] == addr);

  p_shared_region_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !shared_cs_n |-> ((!code_rd_n && !addr[ADDR_W-1]) || (!data_rd_n && addr[ADDR_W-1])));

  p_shared_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!code_rd_n || !data_rd_n) == !shared_oe_n);

  p_big_strobes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (big_oe_n == data_rd_n) && (big_we_n == data_wr_n) &&
    (!big_cs_n == (!data_rd_n || !data_wr_n)));

  p_bank_hold_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(rst_q_n) && !$past(bank_we)) |-> $stable(big_addr[BIG_W-1 -: BANK_W]));

  p_bank_load_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(rst_q_n) && $past(bank_we)) |-> (big_addr[BIG_W-1 -: BANK_W] == $past(bank_wdata)));

  p_reset_clear_r8: assert property (@(posedge clk)
    !rst_n |-> (big_addr[BIG_W-1 -: BANK_W] == '0));
endmodule

bind banked_cs_decoder csdec_chk #(
  .ADDR_W (ADDR_W),
  .SEL_W  (SEL_W),
  .BANK_W (BANK_W),
  .EN_POL (EN_POL)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_q_n     (rst_q_n),
  .addr        (addr),
  .code_rd_n   (code_rd_n),
  .data_rd_n   (data_rd_n),
  .data_wr_n   (data_wr_n),
  .gate_en     (gate_en),
  .bank_we     (bank_we),
  .bank_wdata  (bank_wdata),
  .blk_cs_n    (blk_cs_n),
  .shared_cs_n (shared_cs_n),
  .shared_oe_n (shared_oe_n),
  .big_cs_n    (big_cs_n),
  .big_oe_n    (big_oe_n),
  .big_we_n    (big_we_n),
  .big_addr    (big_addr)
);

// File: tb/banked_cs_decoder_test.sv
`timescale 1ns/1ps
module banked_cs_decoder_test;
  logic        clk;
  logic        rst_n;
  logic [15:0] addr;
  logic        code_rd_n, data_rd_n, data_wr_n;
  logic [2:0]  gate_en;
  logic        bank_we;
  logic [1:0]  bank_wdata;
  logic [7:0]  blk_cs_n;
  logic        shared_cs_n, shared_oe_n, big_cs_n, big_oe_n, big_we_n;
  logic [17:0] big_addr;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  banked_cs_decoder uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .code_rd_n(code_rd_n),
    .data_rd_n(data_rd_n), .data_wr_n(data_wr_n), .gate_en(gate_en),
    .bank_we(bank_we), .bank_wdata(bank_wdata), .blk_cs_n(blk_cs_n),
    .shared_cs_n(shared_cs_n), .shared_oe_n(shared_oe_n), .big_cs_n(big_cs_n),
    .big_oe_n(big_oe_n), .big_we_n(big_we_n), .big_addr(big_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [15:0] a;
    logic        crd, drd, dwr;
    logic [2:0]  en;
    logic [7:0]  blk;
    logic        scs, soe, bcs;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 1'b0, 1'b1, 1'b1, 3'b001, 8'hFE, 1'b0, 1'b0, 1'b1},
    '{16'h2345, 1'b1, 1'b1, 1'b1, 3'b001, 8'hFD, 1'b1, 1'b1, 1'b1},
    '{16'h7FFF, 1'b0, 1'b1, 1'b1, 3'b001, 8'hF7, 1'b0, 1'b0, 1'b1},
    '{16'h8000, 1'b1, 1'b0, 1'b1, 3'b001, 8'hEF, 1'b0, 1'b0, 1'b0},
    '{16'hFFFF, 1'b1, 1'b1, 1'b0, 3'b001, 8'h7F, 1'b1, 1'b1, 1'b0},
    '{16'h8000, 1'b0, 1'b1, 1'b1, 3'b001, 8'hEF, 1'b1, 1'b0, 1'b1},
    '{16'h1000, 1'b1, 1'b0, 1'b1, 3'b001, 8'hFE, 1'b1, 1'b0, 1'b0},
    '{16'hC000, 1'b1, 1'b1, 1'b1, 3'b000, 8'hFF, 1'b1, 1'b1, 1'b1},
    '{16'hA000, 1'b1, 1'b0, 1'b1, 3'b011, 8'hFF, 1'b0, 1'b0, 1'b0},
    '{16'h6000, 1'b0, 1'b1, 1'b1, 3'b101, 8'hFF, 1'b0, 1'b0, 1'b1},
    '{16'hA000, 1'b1, 1'b0, 1'b1, 3'b001, 8'hDF, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = '0; code_rd_n = 1'b1; data_rd_n = 1'b1; data_wr_n = 1'b1;
    gate_en = 3'b001; bank_we = 1'b0; bank_wdata = 2'b11;
    repeat (2) @(negedge clk);
    chk("R8 bank bits in reset", 32'(big_addr[17:16]), 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      addr = VECS[i].a; code_rd_n = VECS[i].crd; data_rd_n = VECS[i].drd;
      data_wr_n = VECS[i].dwr; gate_en = VECS[i].en;
      #1;
      chk("R1/R2 block selects", 32'(blk_cs_n), 32'(VECS[i].blk));
      chk("R4 shared select", 32'(shared_cs_n), 32'(VECS[i].scs));
      chk("R5 shared output enable", 32'(shared_oe_n), 32'(VECS[i].soe));
      chk("R6 big select", 32'(big_cs_n), 32'(VECS[i].bcs));
      chk("R6 big oe/we", 32'({big_oe_n, big_we_n}), 32'({VECS[i].drd, VECS[i].dwr}));
      chk("R3 low address bits", 32'(big_addr[15:0]), 32'(VECS[i].a));
    end

    // R7: write bank 2, visible after the edge
    @(negedge clk);
    code_rd_n = 1'b1; data_rd_n = 1'b1; data_wr_n = 1'b1;
    bank_we = 1'b1; bank_wdata = 2'b10;
    @(negedge clk);
    bank_we = 1'b0; bank_wdata = 2'b01;
    chk("R7 bank load", 32'(big_addr[17:16]), 32'h2);
    repeat (2) @(negedge clk);
    chk("R7 bank hold without write", 32'(big_addr[17:16]), 32'h2);

    // R6: code strobe alone leaves big device idle
    code_rd_n = 1'b0; #1;
    chk("R6 code strobe ignored", 32'({big_cs_n, big_oe_n, big_we_n}), 32'h7);
    code_rd_n = 1'b1;

    // R7: second write
    @(negedge clk);
    bank_we = 1'b1; bank_wdata = 2'b11;
    @(negedge clk);
    bank_we = 1'b0;
    chk("R7 bank load 3", 32'(big_addr[17:16]), 32'h3);

    // R8: asynchronous clear between edges
    #1 rst_n = 1'b0;
    #1 chk("R8 async clear", 32'(big_addr[17:16]), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // writes in the first two edges after release are dropped
    bank_we = 1'b1; bank_wdata = 2'b01;
    @(negedge clk);
    chk("R8 write blocked during release", 32'(big_addr[17:16]), 32'h0);
    @(negedge clk);
    @(negedge clk);
    bank_we = 1'b0;
    chk("R8 write accepted after release", 32'(big_addr[17:16]), 32'h1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule